// File: doc/BRIEF.md
# USB Host Channel Transfer Tracker

This block tracks one host channel of a full-speed USB host controller. Software writes the channel characteristics and the transfer parameters through a small register port, then sets the enable bit. While the channel is enabled, the protocol engine sends one strobe per completed packet, along with the packet's length. For each strobe the block lowers the packet count by one and the remaining byte count by the packet length. It also advances the data PID.

When the packet count runs out, the channel returns to idle on its own and raises a transfer-complete event and a channel-halted event together. If software clears the enable bit during a transfer, the channel waits until the packet in flight has finished, then stops and raises only the halted event. Software may reuse the channel only after it has seen the halted event. The characteristic fields are also driven out as a packed bus for the protocol engine.

Top module: `usb_hchan_tracker`

## Requirements
- R1: After reset, both registers read as zero, the channel reads as disabled, and no event is raised.
- R2: Writing register 0 (characteristics) with bit 31 set while idle enables the channel. Bit 31 reads 1 while the transfer runs. The other fields of register 0 are: max packet size [10:0], endpoint [14:11], IN direction [15], type [17:16] (control=0, isochronous=1, bulk=2, interrupt=3), low speed [18], device address [25:19] and odd frame [26].
- R3: While the channel is busy (running or stopping), writes to register 1 (transfer size) have no effect. Register 1 holds the byte count [18:0], the packet count [28:19] and the PID [30:29].
- R4: Each accepted packet strobe lowers the packet count by exactly one.
- R5: For non-isochronous types, each accepted strobe moves the PID from DATA1 (code 2) to DATA0 (code 0), and from any other code to DATA1. For the isochronous type the PID is unchanged. The other PID codes are DATA2=1 and SETUP=3.
- R6: Each accepted strobe lowers the byte count by the packet length. The result is clamped at zero.
- R7: One cycle after the packet count reaches zero in a running channel, the block pulses complete and halted together for one cycle, and the enable bit reads 0.
- R8: Packet strobes leave every register unchanged while the channel is idle, and also when the packet count is already zero.
- R9: When software writes register 0 with bit 31 clear during a running transfer, strobes are still accepted. The channel stops in the first cycle in which the packet-busy input is low, and it pulses only the halted event.
- R10: While the channel is busy, writes to register 0 leave every characteristic field unchanged.
- R11: Enabling a channel whose packet count is zero completes it on the next cycle with both events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read enable |
| addr_i | input | 1 | Register select: 0 characteristics, 1 transfer size |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when rd_en_i is low |
| pkt_done_i | input | 1 | One-cycle strobe per finished packet |
| pkt_len_i | input | 11 | Byte length of the finished packet |
| pkt_busy_i | input | 1 | A packet is in flight on the bus |
| chan_cfg_o | output | 27 | Characteristic fields for the protocol engine |
| chan_en_o | output | 1 | Channel is running |
| xfer_done_o | output | 1 | Transfer-complete pulse |
| halted_o | output | 1 | Channel-halted pulse |

## Verification
The bench checks the case where the last packet's length is larger than the bytes left, which should clamp the count at zero. A design that wraps would show a huge remaining count. It checks that strobes are ignored once the count is zero or the channel is idle; a design that accepts them would underflow the packet count or toggle the PID again. It also checks the stop path: software clears the enable bit, a strobe arrives while the packet is still busy, and the channel then halts. A design that raised complete there, halted before the packet finished, or dropped that last strobe would produce the wrong event pair or the wrong residual count. Finally, it checks isochronous PID holding and enabling a channel with a zero packet count.

// File: rtl/usb_hchan_pkg.sv
package usb_hchan_pkg;
  localparam int PID_W  = 2;
  localparam int TYPE_W = 2;
  localparam logic [PID_W-1:0]  PID_DATA0 = 2'd0;
  localparam logic [PID_W-1:0]  PID_DATA1 = 2'd2;
  localparam logic [TYPE_W-1:0] TYPE_ISO  = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } ch_state_e;
endpackage

// File: rtl/hchan_char_regs.sv
module hchan_char_regs #(
  parameter int CFG_W    = 27,
  parameter int TYPE_LSB = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wfield_i,
  input  logic             busy_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             iso_o
);
  import usb_hchan_pkg::*;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cfg_q <= '0;
    else if (wr_i && !busy_i) cfg_q <= wfield_i;
  end

  assign cfg_o = cfg_q;
  assign iso_o = (cfg_q[TYPE_LSB +: TYPE_W] == TYPE_ISO);

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/hchan_size_regs.sv
module hchan_size_regs #(
  parameter int BYTE_W = 19,
  parameter int PKT_W  = 10,
  parameter int LEN_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wbytes_i,
  input  logic [PKT_W-1:0]  wpkts_i,
  input  logic [usb_hchan_pkg::PID_W-1:0] wpid_i,
  input  logic              busy_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              iso_i,
  output logic [BYTE_W-1:0] bytes_o,
  output logic [PKT_W-1:0]  pkts_o,
  output logic [usb_hchan_pkg::PID_W-1:0] pid_o,
  output logic              pkts_zero_o
);
  import usb_hchan_pkg::*;

  logic [BYTE_W-1:0] bytes_q, len_ext, bytes_nxt;
  logic [PKT_W-1:0]  pkts_q;
  logic [PID_W-1:0]  pid_q, pid_nxt;

  assign len_ext   = BYTE_W'(len_i);
  assign bytes_nxt = (len_ext >= bytes_q) ? '0 : bytes_q - len_ext;

  always_comb begin
    pid_nxt = pid_q;
    if (!iso_i) pid_nxt = (pid_q == PID_DATA1) ? PID_DATA0 : PID_DATA1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_q <= '0;
      pkts_q  <= '0;
      pid_q   <= PID_DATA0;
    end else if (step_i) begin
      bytes_q <= bytes_nxt;
      pkts_q  <= pkts_q - 1'b1;
      pid_q   <= pid_nxt;
    end else if (wr_i && !busy_i) begin
      bytes_q <= wbytes_i;
      pkts_q  <= wpkts_i;
      pid_q   <= wpid_i;
    end
  end

  assign bytes_o     = bytes_q;
  assign pkts_o      = pkts_q;
  assign pid_o       = pid_q;
  assign pkts_zero_o = (pkts_q == '0);

  AST_NO_PKT_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (pkts_q != '0)); // R8
  AST_SIZE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !step_i) |=> $stable({bytes_q, pkts_q, pid_q})); // R3
  AST_PKT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (pkts_q == $past(pkts_q) - 1'b1)); // R4
  AST_ISO_PID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && iso_i) |=> $stable(pid_q)); // R5
endmodule

// File: rtl/hchan_ctrl.sv
module hchan_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_char_i,
  input  logic en_bit_i,
  input  logic pkt_done_i,
  input  logic pkt_busy_i,
  input  logic pkts_zero_i,
  output logic busy_o,
  output logic run_o,
  output logic step_o,
  output logic done_o,
  output logic halt_o
);
  import usb_hchan_pkg::*;

  ch_state_e state_q;
  logic      done_q, halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      halt_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (wr_char_i && en_bit_i) state_q <= ST_RUN;
        ST_RUN: begin
          if (pkts_zero_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            halt_q  <= 1'b1;
          end else if (wr_char_i && !en_bit_i) begin
            state_q <= ST_STOP;
          end
        end
        ST_STOP: if (!pkt_busy_i) begin
          state_q <= ST_IDLE;
          halt_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign run_o  = (state_q == ST_RUN);
  assign step_o = pkt_done_i && busy_o && !pkts_zero_i;
  assign done_o = done_q;
  assign halt_o = halt_q;

  AST_DONE_WITH_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> halt_q); // R7
  AST_DONE_GOES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE)); // R7
  AST_NO_HALT_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !halt_q); // R9
  AST_STOP_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |=> !done_q); // R9
endmodule

// File: rtl/usb_hchan_tracker.sv
module usb_hchan_tracker #(
  parameter int DATA_W = 32,
  parameter int MPS_W  = 11,
  parameter int EP_W   = 4,
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 19,
  parameter int PKT_W  = 10,
  localparam int CFG_W = MPS_W + EP_W + 1 + usb_hchan_pkg::TYPE_W + 1 + ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pkt_done_i,
  input  logic [MPS_W-1:0]  pkt_len_i,
  input  logic              pkt_busy_i,
  output logic [CFG_W-1:0]  chan_cfg_o,
  output logic              chan_en_o,
  output logic              xfer_done_o,
  output logic              halted_o
);
  import usb_hchan_pkg::*;

  localparam int TYPE_LSB = MPS_W + EP_W + 1;
  localparam int EN_BIT   = DATA_W - 1;
  localparam int PKT_LSB  = BYTE_W;
  localparam int PID_LSB  = BYTE_W + PKT_W;

  logic wr_char, wr_size, busy, run, step, pkts_zero, iso;
  logic [CFG_W-1:0]  cfg;
  logic [BYTE_W-1:0] bytes;
  logic [PKT_W-1:0]  pkts;
  logic [PID_W-1:0]  pid;

  assign wr_char = wr_en_i && !addr_i;
  assign wr_size = wr_en_i &&  addr_i;

  hchan_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_char_i   (wr_char),
    .en_bit_i    (wdata_i[EN_BIT]),
    .pkt_done_i  (pkt_done_i),
    .pkt_busy_i  (pkt_busy_i),
    .pkts_zero_i (pkts_zero),
    .busy_o      (busy),
    .run_o       (run),
    .step_o      (step),
    .done_o      (xfer_done_o),
    .halt_o      (halted_o)
  );

  hchan_char_regs #(.CFG_W(CFG_W), .TYPE_LSB(TYPE_LSB)) u_char (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_char),
    .wfield_i (wdata_i[CFG_W-1:0]),
    .busy_i   (busy),
    .cfg_o    (cfg),
    .iso_o    (iso)
  );

  hchan_size_regs #(.BYTE_W(BYTE_W), .PKT_W(PKT_W), .LEN_W(MPS_W)) u_size (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_size),
    .wbytes_i    (wdata_i[BYTE_W-1:0]),
    .wpkts_i     (wdata_i[PKT_LSB +: PKT_W]),
    .wpid_i      (wdata_i[PID_LSB +: PID_W]),
    .busy_i      (busy),
    .step_i      (step),
    .len_i       (pkt_len_i),
    .iso_i       (iso),
    .bytes_o     (bytes),
    .pkts_o      (pkts),
    .pid_o       (pid),
    .pkts_zero_o (pkts_zero)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (!addr_i) begin
        rdata_o[CFG_W-1:0] = cfg;
        rdata_o[EN_BIT]    = run;
      end else begin
        rdata_o[BYTE_W-1:0]         = bytes;
        rdata_o[PKT_LSB +: PKT_W]   = pkts;
        rdata_o[PID_LSB +: PID_W]   = pid;
      end
    end
  end

  assign chan_cfg_o = cfg;
  assign chan_en_o  = run;

  AST_EN_DROPS_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> !chan_en_o); // R7
  AST_IDLE_STEP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && pkt_done_i) |=> $stable(pkts)); // R8
endmodule

// File: tb/sim_usb_hchan_tracker.sv
module sim_usb_hchan_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pkt_done = 1'b0, pkt_busy = 1'b0;
  logic [10:0] pkt_len = '0;
  logic [26:0] cfg;
  logic        en_o, done_o, halt_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] evq[$];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_hchan_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pkt_done_i(pkt_done), .pkt_len_i(pkt_len), .pkt_busy_i(pkt_busy),
    .chan_cfg_o(cfg), .chan_en_o(en_o), .xfer_done_o(done_o), .halted_o(halt_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_char(input int typ, input int mps, input bit en);
    return 32'(mps) | (32'd2 << 11) | (32'(typ) << 16) | (32'd5 << 19) | (32'(en) << 31);
  endfunction

  function automatic logic [31:0] mk_size(input int b, input int p, input int pid);
    return 32'(b) | (32'(p) << 19) | (32'(pid) << 29);
  endfunction

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic strobe(input int len);
    @(negedge clk); pkt_done = 1'b1; pkt_len = 11'(len);
    @(negedge clk); pkt_done = 1'b0;
  endtask

  task automatic chk_size(input string req, input int b, input int p, input int pid);
    logic [31:0] d;
    rd(1'b1, d);
    chk(d == mk_size(b, p, pid), req, d, mk_size(b, p, pid));
  endtask

  task automatic chk_en(input string req, input bit e);
    logic [31:0] d;
    rd(1'b0, d);
    chk(d[31] == e, req, 32'(d[31]), 32'(e));
  endtask

  // monitor: each event pulse pops one expected {done,halt} pair
  always @(negedge clk) begin
    if (rst_n && (done_o || halt_o)) begin
      if (evq.size() == 0) chk(1'b0, "R7/R9 unexpected event", {30'd0, done_o, halt_o}, 32'd0);
      else begin
        logic [1:0] e;
        e = evq.pop_front();
        chk({done_o, halt_o} == e, "R7/R9 event pair", {30'd0, done_o, halt_o}, {30'd0, e});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, d); chk(d == 32'd0, "R1 char reset", d, 0);
    rd(1'b1, d); chk(d == 32'd0, "R1 size reset", d, 0);
    chk(!done_o && !halt_o && !en_o, "R1 no events", {29'd0, en_o, done_o, halt_o}, 0);

    // bulk transfer of 3 packets
    wr(1'b1, mk_size(200, 3, 0));
    wr(1'b0, mk_char(2, 64, 1'b1));
    rd(1'b0, d); chk(d == mk_char(2, 64, 1'b1), "R2 char readback enabled", d, mk_char(2, 64, 1'b1));
    wr(1'b1, mk_size(50, 1, 3));
    chk_size("R3 size write locked", 200, 3, 0);
    wr(1'b0, mk_char(3, 32, 1'b1));
    rd(1'b0, d); chk(d == mk_char(2, 64, 1'b1), "R10 char write locked", d, mk_char(2, 64, 1'b1));
    strobe(64); chk_size("R4 R5 R6 first packet", 136, 2, 2);
    strobe(64); chk_size("R4 R5 second packet", 72, 1, 0);
    evq.push_back(2'b11);
    strobe(100); chk_size("R6 clamp at zero", 0, 0, 2);
    chk_en("R7 enable held one cycle", 1'b1);
    repeat (2) @(negedge clk);
    chk_en("R7 enable cleared", 1'b0);
    strobe(10); chk_size("R8 idle strobe ignored", 0, 0, 2);

    // isochronous: PID held
    wr(1'b1, mk_size(100, 2, 1));
    wr(1'b0, mk_char(1, 64, 1'b1));
    strobe(40); chk_size("R5 iso PID held", 60, 1, 1);
    evq.push_back(2'b11);
    strobe(40); chk_size("R4 iso last packet", 20, 0, 1);
    strobe(40); chk_size("R8 strobe at zero ignored", 20, 0, 1);
    repeat (2) @(negedge clk);
    chk_en("R7 iso done", 1'b0);

    // software stop during a packet
    pkt_busy = 1'b1;
    wr(1'b1, mk_size(500, 5, 0));
    wr(1'b0, mk_char(2, 64, 1'b1));
    strobe(64); chk_size("R4 before stop", 436, 4, 2);
    wr(1'b0, mk_char(2, 64, 1'b0));
    evq.push_back(2'b01);
    chk_en("R9 enable reads clear", 1'b0);
    strobe(64); chk_size("R9 strobe while stopping", 372, 3, 0);
    wr(1'b1, mk_size(9, 9, 1));
    chk_size("R3 locked while stopping", 372, 3, 0);
    chk(evq.size() == 1, "R9 no halt while busy", 32'(evq.size()), 1);
    @(negedge clk); pkt_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk_size("R9 residual count", 372, 3, 0);

    // zero packet count on enable
    wr(1'b1, mk_size(0, 0, 0));
    evq.push_back(2'b11);
    wr(1'b0, mk_char(2, 64, 1'b1));
    repeat (3) @(negedge clk);
    chk_en("R11 zero count completes", 1'b0);

    repeat (2) @(negedge clk);
    chk(evq.size() == 0, "R7/R9 all events seen", 32'(evq.size()), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule